// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block takes eight external PCI interrupt request pins and turns them into processor interrupt levels. Each pin has a 4-bit level selector that software writes through a small register bus. Selectors for pins 0 to 3 sit in one 16-bit select word, and selectors for pins 4 to 7 sit in a second word. Pin p uses bits [4*(p mod 4)+3 : 4*(p mod 4)] of its word. A 16-bit per-level mask holds a level back from the processor. Software changes the mask only through two write-only ports: one sets mask bits and one clears them.

Requests are level-sensitive. A level stays pending for as long as any pin routed to it is held high. Several pins can share one level. The block presents a registered pending vector with one bit per level, and a registered 4-bit level that names the highest pending level. Board software programs the selectors once, then unmasks the levels it serves. After that, the processor reads the level output, or the pending word, to find out which level needs service.

Top module: `irq_pin_router`

## Requirements
- R1: After reset, both select words read 0, the mask reads 16'hFFFF (all levels masked), and `pend_vec`, `cpu_level` and `bus_rdata` are 0.
- R2: Select word k sits at bus address k (0 holds pins 0-3, 1 holds pins 4-7). Pin p's selector is bits [4*(p mod 4)+3 : 4*(p mod 4)] of word p/4. Each select word reads back exactly what was last written to it.
- R3: A selector value of 0, or of 15, routes the pin nowhere. Such a pin never sets any pending bit.
- R4: A write to the mask-set port (address 4'h9) sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R5: A write to the mask-clear port (address 4'hA) clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value. The mask reads back at address 4'h8.
- R6: Pending bit L (1..14) is 1 when any pin whose selector equals L is high and mask bit L is 0. Pending bits 0 and 15 are always 0.
- R7: When several pins share one level, the level stays pending until the last of those pins goes low.
- R8: `cpu_level` is the index of the highest set bit of `pend_vec`, or 0 when `pend_vec` is 0.
- R9: A pin change shows on `pend_vec` and `cpu_level` after one clock edge. A select or mask write shows there one edge after the write edge. A read returns its data on `bus_rdata` after the read edge, and that value holds until the next read.
- R10: The pending word reads back at address 4'hB. Writes to address 4'h8 or 4'hB change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_req | input | 8 | External interrupt request pins, active high |
| pend_vec | output | 16 | Registered pending levels, one bit per level |
| cpu_level | output | 4 | Registered highest pending level, 0 when none |

## Verification
Some properties are checked on every cycle. The level output must name a pending bit, and no higher bit may be set. Levels 0 and 15 never show pending. A level that was masked in the previous cycle never shows pending. Each set or clear write touches only the bits that are 1 in its data word. No pins high in the previous cycle means an empty pending vector.

Other behaviour only shows under the bench's scenarios:
- the selector field placement
- the treatment of selector values 0 and 15
- a shared level releasing only after its last pin drops
- the read-back of the registers
- the exact latency of pin and register changes

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int PINS_DEF  = 8;
    localparam int SELW_DEF  = 4;
    localparam int WORDW_DEF = 16;
    localparam int ADDRW     = 4;

    // Fixed addresses above the select words
    localparam logic [ADDRW-1:0] ADR_MASK = 4'h8;
    localparam logic [ADDRW-1:0] ADR_MSET = 4'h9;
    localparam logic [ADDRW-1:0] ADR_MCLR = 4'hA;
    localparam logic [ADDRW-1:0] ADR_PEND = 4'hB;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/irq_sel_regs.sv
module irq_sel_regs
    import irq_router_pkg::*;
#(
    parameter int PINS  = PINS_DEF,
    parameter int SELW  = SELW_DEF,
    parameter int WORDW = WORDW_DEF,
    localparam int NLEV  = 1 << SELW,
    localparam int NWORD = (PINS * SELW) / WORDW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [ADDRW-1:0]      bus_addr,
    input  logic [WORDW-1:0]      bus_wdata,
    input  logic [NLEV-1:0]       pend_in,
    output logic [PINS*SELW-1:0]  sel_flat,
    output logic [NLEV-1:0]       mask_q,
    output logic [WORDW-1:0]      rdata_q
);
    acc_kind_e        acc;
    logic [WORDW-1:0] rd_mux;
    logic [PINS*SELW-1:0] sel_q;

    always_comb begin
        if (!bus_en)     acc = ACC_NONE;
        else if (bus_we) acc = ACC_WRITE;
        else             acc = ACC_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            mask_q <= '1;
        end else if (acc == ACC_WRITE) begin
            for (int w = 0; w < NWORD; w++) begin
                if (bus_addr == ADDRW'(w))
                    sel_q[w*WORDW +: WORDW] <= bus_wdata;
            end
            if (bus_addr == ADR_MSET) mask_q <= mask_q | NLEV'(bus_wdata);
            if (bus_addr == ADR_MCLR) mask_q <= mask_q & ~NLEV'(bus_wdata);
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < NWORD; w++) begin
            if (bus_addr == ADDRW'(w))
                rd_mux = sel_q[w*WORDW +: WORDW];
        end
        if (bus_addr == ADR_MASK) rd_mux = WORDW'(mask_q);
        if (bus_addr == ADR_PEND) rd_mux = WORDW'(pend_in);
    end

    always_ff @(posedge clk) begin
        if (rst)                  rdata_q <= '0;
        else if (acc == ACC_READ) rdata_q <= rd_mux;
    end

    assign sel_flat = sel_q;
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
    import irq_router_pkg::*;
#(
    parameter int PINS = PINS_DEF,
    parameter int SELW = SELW_DEF,
    localparam int NLEV = 1 << SELW
) (
    input  logic [PINS-1:0]      pins,
    input  logic [PINS*SELW-1:0] sel_flat,
    input  logic [NLEV-1:0]      mask,
    output logic [NLEV-1:0]      pend
);
    genvar lv;
    generate
        for (lv = 0; lv < NLEV; lv++) begin : g_lev
            if (lv == 0 || lv == NLEV - 1) begin : g_dead
                assign pend[lv] = 1'b0;
            end else begin : g_live
                logic hit;
                always_comb begin
                    hit = 1'b0;
                    for (int p = 0; p < PINS; p++) begin
                        if (pins[p] && sel_flat[p*SELW +: SELW] == SELW'(lv))
                            hit = 1'b1;
                    end
                end
                assign pend[lv] = hit & ~mask[lv];
            end
        end
    endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_router_pkg::*;
#(
    parameter int SELW = SELW_DEF,
    localparam int NLEV = 1 << SELW
) (
    input  logic [NLEV-1:0] pend,
    output logic [SELW-1:0] level
);
    always_comb begin
        level = '0;
        for (int l = 1; l < NLEV; l++) begin
            if (pend[l]) level = SELW'(l);
        end
    end
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
    import irq_router_pkg::*;
#(
    parameter int PINS  = PINS_DEF,
    parameter int SELW  = SELW_DEF,
    parameter int WORDW = WORDW_DEF,
    localparam int NLEV = 1 << SELW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDRW-1:0]  bus_addr,
    input  logic [WORDW-1:0]  bus_wdata,
    output logic [WORDW-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pin_req,
    output logic [NLEV-1:0]   pend_vec,
    output logic [SELW-1:0]   cpu_level
);
    logic [PINS*SELW-1:0] sel_w;
    logic [NLEV-1:0]      mask_w;
    logic [NLEV-1:0]      pend_d;
    logic [SELW-1:0]      level_d;
    logic [NLEV-1:0]      pend_q;
    logic [SELW-1:0]      level_q;

    irq_sel_regs #(.PINS(PINS), .SELW(SELW), .WORDW(WORDW)) u_regs (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_in(pend_q),
        .sel_flat(sel_w), .mask_q(mask_w), .rdata_q(bus_rdata)
    );

    irq_route_matrix #(.PINS(PINS), .SELW(SELW)) u_matrix (
        .pins(pin_req), .sel_flat(sel_w), .mask(mask_w), .pend(pend_d)
    );

    irq_prio_pick #(.SELW(SELW)) u_prio (
        .pend(pend_d), .level(level_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            level_q <= '0;
        end else begin
            pend_q  <= pend_d;
            level_q <= level_d;
        end
    end

    assign pend_vec  = pend_q;
    assign cpu_level = level_q;
endmodule

// File: rtl/irq_pin_router_chk.sv
module irq_pin_router_chk
    import irq_router_pkg::*;
#(
    parameter int PINS  = PINS_DEF,
    parameter int SELW  = SELW_DEF,
    parameter int WORDW = WORDW_DEF,
    localparam int NLEV = 1 << SELW
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDRW-1:0]  bus_addr,
    input logic [WORDW-1:0]  bus_wdata,
    input logic [PINS-1:0]   pin_req,
    input logic [NLEV-1:0]   pend_vec,
    input logic [SELW-1:0]   cpu_level,
    input logic [NLEV-1:0]   mask_q
);
    AST_LEVEL_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (cpu_level != '0) |-> pend_vec[cpu_level]); // R8
    AST_LEVEL_IS_TOP: assert property (@(posedge clk) disable iff (rst)
        (pend_vec >> cpu_level) <= NLEV'(1)); // R8
    AST_EDGE_LEVELS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pend_vec[0] && !pend_vec[NLEV-1]); // R3
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (pend_vec & $past(mask_q)) == '0); // R6
    AST_QUIET_PINS: assert property (@(posedge clk) disable iff (rst)
        ($past(pin_req) == '0) |-> (pend_vec == '0)); // R7
    AST_SET_PORT: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == ADR_MSET) |=>
        (mask_q == ($past(mask_q) | $past(NLEV'(bus_wdata))))); // R4
    AST_CLR_PORT: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == ADR_MCLR) |=>
        (mask_q == ($past(mask_q) & ~$past(NLEV'(bus_wdata))))); // R5
    AST_RO_MASK: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && (bus_addr == ADR_MASK || bus_addr == ADR_PEND)) |=>
        $stable(mask_q)); // R10
endmodule

bind irq_pin_router irq_pin_router_chk #(.PINS(PINS), .SELW(SELW), .WORDW(WORDW)) chk_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_req(pin_req),
    .pend_vec(pend_vec), .cpu_level(cpu_level), .mask_q(mask_w)
);

// File: tb/irq_pin_router_tb_top.sv
`timescale 1ns/1ps
module irq_pin_router_tb_top;
    import irq_router_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_req = '0;
    logic [15:0] pend_vec;
    logic [3:0]  cpu_level;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_pin_router dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_req(pin_req), .pend_vec(pend_vec), .cpu_level(cpu_level)
    );

    typedef struct packed {
        logic [15:0] lo;
        logic [15:0] hi;
        logic [15:0] clr;
        logic [7:0]  pins;
        logic [15:0] pend;
        logic [3:0]  lvl;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h4321, 16'h0000, 16'hFFFF, 8'h0F, 16'h001E, 4'd4},  // R2 R8 low word
        '{16'h4321, 16'h0000, 16'hFFFF, 8'h05, 16'h000A, 4'd3},  // R6 subset
        '{16'h4321, 16'hE98D, 16'hFFFF, 8'hF0, 16'h6300, 4'd14}, // R2 high word
        '{16'h4321, 16'hE98D, 16'h3FFF, 8'hF0, 16'h2300, 4'd13}, // R6 level 14 masked
        '{16'h0666, 16'h0000, 16'hFFFF, 8'h0A, 16'h0040, 4'd6},  // R3 pin3 unrouted
        '{16'h0666, 16'h0000, 16'hFFFF, 8'h08, 16'h0000, 4'd0},  // R3 only unrouted pin
        '{16'h000F, 16'h0000, 16'hFFFF, 8'h01, 16'h0000, 4'd0},  // R3 selector 15
        '{16'h4321, 16'h0000, 16'h0000, 8'h0F, 16'h0000, 4'd0}   // R6 all masked
    };

    task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h", what, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pend_vec", pend_vec, 16'h0000);
        chk("R1 cpu_level", {12'h0, cpu_level}, 16'h0000);
        chk("R1 rdata", bus_rdata, 16'h0000);
        rd(4'h0, r); chk("R1 sel word0", r, 16'h0000);
        rd(4'h1, r); chk("R1 sel word1", r, 16'h0000);
        rd(ADR_MASK, r); chk("R1 mask", r, 16'hFFFF);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            wr(4'h0, VECS[i].lo);
            wr(4'h1, VECS[i].hi);
            wr(ADR_MSET, 16'hFFFF);
            wr(ADR_MCLR, VECS[i].clr);
            pin_req = VECS[i].pins;
            @(negedge clk);
            chk($sformatf("R6 vec%0d pend", i), pend_vec, VECS[i].pend);
            chk($sformatf("R8 vec%0d level", i), {12'h0, cpu_level}, {12'h0, VECS[i].lvl});
        end

        // R2 read back
        wr(4'h0, 16'hA5C3); wr(4'h1, 16'h3C5A);
        rd(4'h0, r); chk("R2 word0 readback", r, 16'hA5C3);
        rd(4'h1, r); chk("R2 word1 readback", r, 16'h3C5A);

        // R4 / R5 zero bits ignored
        pin_req = '0;
        wr(ADR_MSET, 16'hFFFF);
        wr(ADR_MCLR, 16'h0010);
        rd(ADR_MASK, r); chk("R5 clear one bit", r, 16'hFFEF);
        wr(ADR_MSET, 16'h0000);
        rd(ADR_MASK, r); chk("R4 zero set no effect", r, 16'hFFEF);
        wr(ADR_MCLR, 16'h0000);
        rd(ADR_MASK, r); chk("R5 zero clear no effect", r, 16'hFFEF);
        wr(ADR_MSET, 16'h0010);
        rd(ADR_MASK, r); chk("R4 set one bit", r, 16'hFFFF);

        // R10 read-only addresses
        wr(ADR_MASK, 16'h0000);
        rd(ADR_MASK, r); chk("R10 mask write ignored", r, 16'hFFFF);

        // R7 shared level release
        wr(4'h0, 16'h0666); wr(4'h1, 16'h0000);
        wr(ADR_MCLR, 16'hFFFF);
        pin_req = 8'h07; @(negedge clk);
        chk("R7 shared all", {12'h0, cpu_level}, 16'd6);
        pin_req = 8'h06; @(negedge clk);
        chk("R7 shared two left", {12'h0, cpu_level}, 16'd6);
        pin_req = 8'h04; @(negedge clk);
        chk("R7 shared one left", pend_vec, 16'h0040);
        rd(ADR_PEND, r); chk("R10 pend readback", r, 16'h0040);
        wr(ADR_PEND, 16'hFFFF);
        chk("R10 pend write ignored", pend_vec, 16'h0040);
        pin_req = 8'h00; @(negedge clk);
        chk("R7 shared released", pend_vec, 16'h0000);
        chk("R7 level released", {12'h0, cpu_level}, 16'd0);

        // R9 latency
        wr(4'h0, 16'h0001);
        pin_req = 8'h01;
        chk("R9 pin before edge", {12'h0, cpu_level}, 16'd0);
        @(negedge clk);
        chk("R9 pin after edge", {12'h0, cpu_level}, 16'd1);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 16'h0005;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        chk("R9 write edge old level", {12'h0, cpu_level}, 16'd1);
        @(negedge clk);
        chk("R9 write next edge new level", {12'h0, cpu_level}, 16'd5);
        rd(4'h1, r);
        @(negedge clk);
        chk("R9 rdata held", bus_rdata, 16'h0000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule